// File: doc/BRIEF.md
# Burst-of-Two Split-Port Memory Core

This block is a synthesizable memory with a dedicated read data port and a dedicated write data port that share one address bus. Every location holds a pair of words, and every access moves the pair as a burst of two beats. The two clock halves of a double-data-rate interface are modelled by one rising-edge clock running at beat rate and an internal phase bit. Phase 0 is the main edge, on which requests are taken. Phase 1 is the complementary edge, on which the write address and the second write beat are taken.

A read returns the lower word and then the upper word, starting one main cycle after the request. A write stores both beats once they have arrived, and a per-beat byte mask controls which 9-bit lanes change. A read that starts in the same main cycle as a write to the same location, or in the cycle after it, sees the new data. When no read is pending the output enable drops and the data bus is driven to zero.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, `rd_oe` and `rd_first` are 0, `rdata` is 0 and `ph_o` is 0. Reset takes effect at once, even in the middle of a burst.
- R2: `ph_o` is 0 out of reset and toggles on every clock edge. An edge taken while `ph_o` is 0 is a main edge. `rd_sel_n` and `wr_sel_n` have no effect on edges taken while `ph_o` is 1.
- R3: A read is requested by `rd_sel_n` low on a main edge, with `addr` as the location. After the next main edge, `rdata` carries the lower word with `rd_oe`=1 and `rd_first`=1. After the following edge it carries the upper word with `rd_oe`=1 and `rd_first`=0.
- R4: A write is requested by `wr_sel_n` low on a main edge, which also takes the first beat (`wdata`, `bwe_n`). The next edge takes the write address from `addr` and the second beat, which are stored as the lower and upper word.
- R5: `bwe_n` is active low with one bit per 9-bit lane, and bit n guards `wdata[9n+8:9n]`. A lane whose bit is 1 keeps its stored value. Each beat uses its own mask.
- R6: A read of a location returns data that includes every write started on the same main edge as the read or on an earlier one.
- R7: Reads and writes can be requested on the same main edge to different locations, and neither affects the other.
- R8: After a main edge with no pending read, `rd_oe` is 0 and `rdata` is 0. Reads on back-to-back main edges keep `rd_oe` high without a gap.
- R9: When `wr_sel_n` is high on a main edge, the values on `wdata`, `bwe_n` and `addr` do not change memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read request, active low, taken on main edges |
| wr_sel_n | input | 1 | Write request, active low, taken on main edges |
| addr | input | ADDR_W | Read address on main edges, write address on complementary edges |
| wdata | input | WIDTH | Write beat data |
| bwe_n | input | WIDTH/9 | Per-lane write mask for the current beat, active low |
| ph_o | output | 1 | Phase of the next edge: 0 main, 1 complementary |
| rdata | output | WIDTH | Read burst data, zero when idle |
| rd_oe | output | 1 | Read data enable |
| rd_first | output | 1 | High on the beat carrying the lower word |

## Verification
The bench targets the following corner cases:
- A read in the same main cycle as a write to the same location. A core without a bypass on the commit edge returns the stale lower and upper words.
- A read in the cycle after a write. A commit that came a cycle late would show up here.
- Partial masks that differ between the two beats, including a write with every lane masked. A wrong lane slice or a shared mask corrupts the neighbouring lane.
- Selects pulled low only on complementary edges, a deselected write carrying junk data, and a reset in the middle of a burst. Each of these exposes stray bursts, stray writes or an output enable that stays high.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
   localparam int LANE_W = 9;
   typedef enum logic {
      PH_MAIN = 1'b0,
      PH_COMP = 1'b1
   } phase_e;
endpackage

// File: rtl/qdr_phase.sv
module qdr_phase
   import qdr_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_e ph
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_MAIN;
      else        ph <= (ph == PH_MAIN) ? PH_COMP : PH_MAIN;
   end

   assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_MAIN) |=> (ph == PH_COMP));
   assert_phase_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_COMP) |=> (ph == PH_MAIN));
endmodule

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture
   import qdr_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int ADDR_W = 6,
   parameter int LANES  = WIDTH / LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            ph,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [LANES-1:0]  bwe_n,
   output logic              commit,
   output logic [ADDR_W-1:0] c_addr,
   output logic [WIDTH-1:0]  c_d0,
   output logic [LANES-1:0]  c_m0,
   output logic [WIDTH-1:0]  c_d1,
   output logic [LANES-1:0]  c_m1
);
   logic wr_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend <= 1'b0;
         commit  <= 1'b0;
         c_addr  <= '0;
         c_d0    <= '0;
         c_m0    <= '1;
         c_d1    <= '0;
         c_m1    <= '1;
      end else if (ph == PH_MAIN) begin
         wr_pend <= !wr_sel_n;
         commit  <= 1'b0;
         if (!wr_sel_n) begin
            c_d0 <= wdata;
            c_m0 <= bwe_n;
         end
      end else begin
         wr_pend <= 1'b0;
         commit  <= wr_pend;
         if (wr_pend) begin
            c_addr <= addr;
            c_d1   <= wdata;
            c_m1   <= bwe_n;
         end
      end
   end

   assert_commit_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (ph == PH_MAIN));
   assert_pend_comp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pend |-> (ph == PH_COMP));
   assert_commit_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && ph == PH_COMP) |=> commit);
endmodule

// File: rtl/qdr_bank.sv
module qdr_bank
   import qdr_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int ADDR_W = 6,
   parameter int LANES  = WIDTH / LANE_W
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wd,
   input  logic [LANES-1:0]  wm_n,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] old_w;
   logic [WIDTH-1:0] merged;

   assign old_w = mem[waddr];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*LANE_W +: LANE_W] = wm_n[l] ? old_w[l*LANE_W +: LANE_W]
                                                  : wd[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= merged;
   end

   always_comb begin
      if (we && (waddr == raddr)) q = merged;
      else                        q = mem[raddr];
   end
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe
   import qdr_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int ADDR_W = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            ph,
   input  logic              rd_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  lo_q,
   input  logic [WIDTH-1:0]  hi_q,
   output logic [ADDR_W-1:0] r_addr,
   output logic [WIDTH-1:0]  rdata,
   output logic              rd_oe,
   output logic              rd_first
);
   logic             rd_pend;
   logic [WIDTH-1:0] hold_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend  <= 1'b0;
         r_addr   <= '0;
         hold_hi  <= '0;
         rdata    <= '0;
         rd_oe    <= 1'b0;
         rd_first <= 1'b0;
      end else if (ph == PH_MAIN) begin
         rd_pend <= !rd_sel_n;
         if (!rd_sel_n) r_addr <= addr;
         rd_oe    <= rd_pend;
         rd_first <= rd_pend;
         rdata    <= rd_pend ? lo_q : '0;
         hold_hi  <= rd_pend ? hi_q : '0;
      end else begin
         rd_first <= 1'b0;
         rdata    <= rd_oe ? hold_hi : '0;
      end
   end

   assert_burst_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_MAIN && rd_pend) |=> (rd_oe && rd_first));
   assert_first_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_first |=> (rd_oe && !rd_first));
   assert_oe_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_MAIN && !rd_pend) |=> !rd_oe);
   assert_oe_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_COMP) |=> $stable(rd_oe));
   assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe |-> (rdata == '0));
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
   import qdr_pkg::*;
#(
   parameter int WIDTH  = 18,
   parameter int ADDR_W = 6
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_sel_n,
   input  logic                      wr_sel_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [WIDTH-1:0]          wdata,
   input  logic [WIDTH/LANE_W-1:0]   bwe_n,
   output logic                      ph_o,
   output logic [WIDTH-1:0]          rdata,
   output logic                      rd_oe,
   output logic                      rd_first
);
   localparam int LANES = WIDTH / LANE_W;

   initial begin
      assert (WIDTH % LANE_W == 0 && WIDTH > 0)
         else $error("WIDTH must be a positive multiple of the lane width");
      assert (ADDR_W >= 1 && ADDR_W <= 12)
         else $error("ADDR_W out of supported range");
   end

   phase_e            ph;
   logic              commit;
   logic [ADDR_W-1:0] c_addr;
   logic [ADDR_W-1:0] r_addr;
   logic [WIDTH-1:0]  bd [2];
   logic [LANES-1:0]  bm [2];
   logic [WIDTH-1:0]  bq [2];

   assign ph_o = (ph == PH_COMP);

   qdr_phase u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .ph    (ph)
   );

   qdr_wr_capture #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .LANES(LANES)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .wr_sel_n (wr_sel_n),
      .addr     (addr),
      .wdata    (wdata),
      .bwe_n    (bwe_n),
      .commit   (commit),
      .c_addr   (c_addr),
      .c_d0     (bd[0]),
      .c_m0     (bm[0]),
      .c_d1     (bd[1]),
      .c_m1     (bm[1])
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      qdr_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
         .clk   (clk),
         .we    (commit),
         .waddr (c_addr),
         .wd    (bd[b]),
         .wm_n  (bm[b]),
         .raddr (r_addr),
         .q     (bq[b])
      );
   end

   qdr_rd_pipe #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .rd_sel_n (rd_sel_n),
      .addr     (addr),
      .lo_q     (bq[0]),
      .hi_q     (bq[1]),
      .r_addr   (r_addr),
      .rdata    (rdata),
      .rd_oe    (rd_oe),
      .rd_first (rd_first)
   );
endmodule

// File: tb/tb_qdr_burst_sram.sv
module tb_qdr_burst_sram;
   localparam int W  = 18;
   localparam int AW = 6;
   localparam int L  = W / 9;
   localparam int NV = 14;
   localparam int VW = 1 + AW + 1 + AW + W + L + W + L + 1;

   // {rd, raddr, wr, waddr, d0, m0, d1, m1, phase1_selects_low}
   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 6'd0,  1'b1, 6'd5,  18'h12345, 2'b00, 18'h2ABCD, 2'b00, 1'b0},
      {1'b1, 6'd5,  1'b1, 6'd7,  18'h00111, 2'b00, 18'h3FFFF, 2'b00, 1'b0},
      {1'b1, 6'd7,  1'b1, 6'd7,  18'h15555, 2'b01, 18'h0AAAA, 2'b10, 1'b0},
      {1'b0, 6'd0,  1'b0, 6'd0,  18'h0,     2'b00, 18'h0,     2'b00, 1'b0},
      {1'b1, 6'd7,  1'b0, 6'd7,  18'h3C3C3, 2'b00, 18'h1E1E1, 2'b00, 1'b0},
      {1'b1, 6'd5,  1'b0, 6'd5,  18'h0,     2'b00, 18'h0,     2'b00, 1'b1},
      {1'b0, 6'd5,  1'b0, 6'd5,  18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, 1'b1},
      {1'b1, 6'd5,  1'b1, 6'd10, 18'h1FFFF, 2'b00, 18'h00001, 2'b00, 1'b0},
      {1'b1, 6'd10, 1'b1, 6'd10, 18'h2468A, 2'b11, 18'h13579, 2'b11, 1'b0},
      {1'b1, 6'd10, 1'b1, 6'd12, 18'h0F0F0, 2'b00, 18'h30303, 2'b00, 1'b0},
      {1'b1, 6'd12, 1'b1, 6'd10, 18'h2AAAA, 2'b10, 18'h15555, 2'b01, 1'b0},
      {1'b1, 6'd10, 1'b0, 6'd0,  18'h0,     2'b00, 18'h0,     2'b00, 1'b0},
      {1'b0, 6'd0,  1'b0, 6'd0,  18'h0,     2'b00, 18'h0,     2'b00, 1'b0},
      {1'b0, 6'd0,  1'b0, 6'd0,  18'h0,     2'b00, 18'h0,     2'b00, 1'b0}
   };

   function automatic string vtag(int i);
      case (i)
         1:       return "R6";
         2:       return "R5";
         4:       return "R9";
         5, 6:    return "R2";
         7:       return "R7";
         8:       return "R5";
         9, 10:   return "R7";
         default: return "R3";
      endcase
   endfunction

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1;
   logic          wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wdata = '0;
   logic [L-1:0]  bwe_n = '1;
   logic          ph_o;
   logic [W-1:0]  rdata;
   logic          rd_oe;
   logic          rd_first;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [W-1:0] ref_lo [1 << AW];
   logic [W-1:0] ref_hi [1 << AW];
   bit           p1_rd = 1'b0, p2_rd = 1'b0;
   logic [W-1:0] p1_lo = '0, p1_hi = '0, p2_hi = '0;

   always #2 clk = ~clk;

   qdr_burst_sram #(.WIDTH(W), .ADDR_W(AW)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_sel_n (rd_sel_n),
      .wr_sel_n (wr_sel_n),
      .addr     (addr),
      .wdata    (wdata),
      .bwe_n    (bwe_n),
      .ph_o     (ph_o),
      .rdata    (rdata),
      .rd_oe    (rd_oe),
      .rd_first (rd_first)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] d,
                                          input logic [L-1:0] m);
      logic [W-1:0] r = old;
      for (int l = 0; l < L; l++) if (!m[l]) r[l*9 +: 9] = d[l*9 +: 9];
      return r;
   endfunction

   task automatic main_cycle(input logic [VW-1:0] v, input string tag);
      bit            rs, ws, junk;
      logic [AW-1:0] ra, wa;
      logic [W-1:0]  d0, d1, cur_lo, cur_hi;
      logic [L-1:0]  m0, m1;
      {rs, ra, ws, wa, d0, m0, d1, m1, junk} = v;
      @(negedge clk);
      while (ph_o) @(negedge clk);
      // upper word of the read two main cycles back (R3, R8)
      chk(p2_rd ? "R3" : "R8", "oe upper beat", 32'(rd_oe), 32'(p2_rd));
      chk("R3", "first on upper beat", 32'(rd_first), 32'h0);
      chk(p2_rd ? tag : "R8", "upper data", 32'(rdata), p2_rd ? 32'(p2_hi) : 32'h0);
      rd_sel_n = !rs; wr_sel_n = !ws; addr = ra; wdata = d0; bwe_n = m0;
      if (ws) begin
         ref_lo[wa] = merge(ref_lo[wa], d0, m0);
         ref_hi[wa] = merge(ref_hi[wa], d1, m1);
      end
      cur_lo = ref_lo[ra];
      cur_hi = ref_hi[ra];
      @(negedge clk);
      chk(p1_rd ? "R3" : "R8", "oe lower beat", 32'(rd_oe), 32'(p1_rd));
      chk("R3", "first on lower beat", 32'(rd_first), 32'(p1_rd));
      chk(p1_rd ? tag : "R8", "lower data", 32'(rdata), p1_rd ? 32'(p1_lo) : 32'h0);
      addr = wa; wdata = d1; bwe_n = m1;
      rd_sel_n = !junk; wr_sel_n = !junk;
      p2_rd = p1_rd; p2_hi = p1_hi;
      p1_rd = rs; p1_lo = cur_lo; p1_hi = cur_hi;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1", "oe in reset", 32'(rd_oe), 32'h0);
      chk("R1", "rdata in reset", 32'(rdata), 32'h0);
      chk("R1", "phase in reset", 32'(ph_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", "phase after one edge", 32'(ph_o), 32'h1);
      @(negedge clk);
      chk("R2", "phase after two edges", 32'(ph_o), 32'h0);
      chk("R1", "first after reset", 32'(rd_first), 32'h0);

      for (int i = 0; i < NV; i++) main_cycle(VEC[i], vtag(i));

      // R1: reset in the middle of a burst
      main_cycle({1'b1, 6'd12, 1'b0, 6'd0, 18'h0, 2'b00, 18'h0, 2'b00, 1'b0}, "R3");
      main_cycle('0, "R3");
      rst_n = 1'b0;
      #1;
      chk("R1", "oe cut by reset", 32'(rd_oe), 32'h0);
      chk("R1", "rdata cut by reset", 32'(rdata), 32'h0);
      chk("R1", "phase cut by reset", 32'(ph_o), 32'h0);
      rd_sel_n = 1'b1; wr_sel_n = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      p1_rd = 1'b0; p2_rd = 1'b0;
      main_cycle('0, "R1");
      main_cycle('0, "R1");
      // R9: location 12 kept its value across the reset
      main_cycle({1'b1, 6'd12, 1'b0, 6'd0, 18'h0, 2'b00, 18'h0, 2'b00, 1'b0}, "R9");
      main_cycle('0, "R9");
      main_cycle('0, "R9");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule